// File: doc/BRIEF.md
# Oscillator Clock Quality Checker

This block decides whether an external oscillator clock can be trusted. It runs entirely on a reference clock, which is the free-running self-clock output of a PLL while a check is in progress. The oscillator clock is brought into the reference domain through a flop synchronizer. Its rising edges are then counted inside a check window of `WIN_CYCLES` reference cycles. When `OK_EDGES` edges have been seen inside one window, the oscillator is declared good. The window stops at that edge, and self-clock mode is released. A window that expires short of the threshold is discarded, and a fresh window starts on the next cycle.

A check starts on any of four triggers. The first is the power-on reset, given by the release of `rst_n`. The other three are a low-voltage reset pulse, a wake-up from full stop mode, and a failure of the coarse missing-clock monitor. The monitor flags a failure when `MISS_CYCLES` consecutive reference cycles pass with no detected oscillator edge. A control input chooses what a failure does:
- With the input set, it enters self-clock mode and restarts the quality check.
- With the input clear, it issues a one-cycle system reset request instead.

While the monitor is disabled, it never reports a failure.

The reference clock must run more than twice as fast as the oscillator.

Top module: `osc_quality_mon`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `chk_busy`=1, `scm_on`=1, `osc_ok`=0 and `rst_req`=0. Releasing reset starts a check exactly like a power-on event.
- R2: An oscillator rising edge is counted two reference cycles after it is sampled. In the cycle after the `OK_EDGES`-th counted edge of the current window, `osc_ok` becomes 1 while `chk_busy` and `scm_on` become 0, without waiting for the window end.
- R3: A window lasts `WIN_CYCLES` reference cycles. If it ends with fewer than `OK_EDGES` edges, `osc_ok` stays 0 and `scm_on` stays 1. The edge count restarts from zero in a new window on the next cycle, so edges never carry over between windows.
- R4: A one-cycle pulse on `lvr_evt` or on `wake_evt` starts a new check. The next cycle shows `chk_busy`=1, `osc_ok`=0 and `scm_on`=1, even if the oscillator had already been declared good.
- R5: With `mon_en`=1, a failure occurs when `MISS_CYCLES` consecutive cycles pass with no detected edge. If `fail_scm_sel`=1, a failure has the same effect as a start trigger (R4).
- R6: If `fail_scm_sel`=0, a failure produces exactly a one-cycle pulse on `rst_req` in the following cycle. It leaves `osc_ok`, `chk_busy` and `scm_on` unchanged.
- R7: While `mon_en`=0, no failure occurs and the missing-edge count is held at zero, however long the oscillator is stopped.
- R8: Every detected edge clears the missing-edge count. An oscillator whose detected edges are fewer than `MISS_CYCLES` cycles apart never causes a failure.
- R9: A start trigger in the same cycle as the threshold-reaching edge wins. The next cycle shows `osc_ok`=0 and `chk_busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference (self-clock) clock; all state is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset; its release starts a check |
| osc_clk | input | 1 | Oscillator clock under test, asynchronous to `ref_clk` |
| lvr_evt | input | 1 | Low-voltage reset event, one-cycle pulse synchronous to `ref_clk` |
| wake_evt | input | 1 | Full-stop wake-up event, one-cycle pulse synchronous to `ref_clk` |
| mon_en | input | 1 | 1 enables the missing-clock monitor |
| fail_scm_sel | input | 1 | Monitor failure response: 1 enters self-clock mode and restarts the check, 0 requests a reset |
| osc_ok | output | 1 | Oscillator declared good by the last completed check |
| chk_busy | output | 1 | A quality check is in progress |
| scm_on | output | 1 | Self-clock mode is active |
| rst_req | output | 1 | One-cycle system reset request after a monitor failure |

## Verification
The hardest situation to reach from the ports is R9: a start trigger that lands in exactly the cycle in which the threshold edge is counted. Because of the synchronizer delay, that cycle cannot be read from the oscillator waveform alone. The bench's behavioural model tracks the sampled oscillator history and the window's edge count. The stimulus waits until the model shows the count one below threshold with a rising edge pending for the next clock, and raises `lvr_evt` for that clock. Monitor failures are provoked by stopping the oscillator with the monitor enabled and disabled, under both failure responses. A slow oscillator just under the per-window threshold shows that counts are discarded at window end.

// File: rtl/osc_qm_pkg.sv
package osc_qm_pkg;
   // Result state of the fine quality check.
   typedef struct packed {
      logic ok;
      logic busy;
      logic scm;
   } qchk_state_t;

   localparam qchk_state_t QCHK_START = '{ok: 1'b0, busy: 1'b1, scm: 1'b1};
   localparam qchk_state_t QCHK_PASS  = '{ok: 1'b1, busy: 1'b0, scm: 1'b0};
endpackage

// File: rtl/osc_qm_sync.sv
module osc_qm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("osc_qm_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;

   // R2: a detected rise is one cycle wide
   p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/osc_qm_miss.sv
module osc_qm_miss #(
   parameter int MISS_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic osc_rise,
   output logic fail
);
   localparam int MW = $clog2(MISS_CYCLES);
   localparam logic [MW-1:0] MISS_LAST = MW'(MISS_CYCLES - 1);

   logic [MW-1:0] idle_cnt;

   if (MISS_CYCLES < 2) begin : g_bad_miss
      $error("osc_qm_miss: MISS_CYCLES must be at least 2");
   end

   assign fail = enable & ~osc_rise & (idle_cnt == MISS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idle_cnt <= '0;
      else if (!enable || osc_rise) idle_cnt <= '0;
      else if (fail)               idle_cnt <= '0;
      else                         idle_cnt <= idle_cnt + 1'b1;
   end

   // R7: disabled monitor never fails and keeps its count cleared
   p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> idle_cnt == '0);
   // R8: a failure cannot follow directly after a detected edge
   p_edge_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      osc_rise |=> !fail);
   // R5: count stays within the timeout
   p_idle_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cnt <= MISS_LAST);
endmodule

// File: rtl/osc_qm_window.sv
module osc_qm_window
   import osc_qm_pkg::*;
#(
   parameter int WIN_CYCLES = 50000,
   parameter int OK_EDGES   = 4096
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        osc_rise,
   output qchk_state_t st
);
   localparam int WW = $clog2(WIN_CYCLES);
   localparam int CW = $clog2(OK_EDGES);
   localparam logic [WW-1:0] WIN_LAST  = WW'(WIN_CYCLES - 1);
   localparam logic [CW-1:0] EDGE_LAST = CW'(OK_EDGES - 1);

   logic [WW-1:0] win_cnt;
   logic [CW-1:0] edge_cnt;
   logic          reach;

   if (WIN_CYCLES < 2 || OK_EDGES < 2) begin : g_bad_window
      $error("osc_qm_window: WIN_CYCLES and OK_EDGES must be at least 2");
   end

   assign reach = osc_rise & (edge_cnt == EDGE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= QCHK_START;
         win_cnt  <= '0;
         edge_cnt <= '0;
      end else if (start) begin
         st       <= QCHK_START;
         win_cnt  <= '0;
         edge_cnt <= '0;
      end else if (st.busy) begin
         if (reach) begin
            st       <= QCHK_PASS;
            win_cnt  <= '0;
            edge_cnt <= '0;
         end else if (win_cnt == WIN_LAST) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
         end else begin
            win_cnt  <= win_cnt + 1'b1;
            edge_cnt <= edge_cnt + CW'(osc_rise);
         end
      end
   end

   // R4: any start yields a fresh check
   p_start_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> st.busy && !st.ok && st.scm);
   // R2: a good oscillator ends the check and self-clock mode
   p_ok_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st.ok |-> !st.busy && !st.scm);
   // R3: window counter stays inside the window
   p_win_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_cnt <= WIN_LAST);
   // R3: an idle checker holds its counters
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !st.busy && !start |=> $stable(win_cnt) && $stable(edge_cnt));
endmodule

// File: rtl/osc_quality_mon.sv
module osc_quality_mon
   import osc_qm_pkg::*;
#(
   parameter int WIN_CYCLES  = 50000,
   parameter int OK_EDGES    = 4096,
   parameter int MISS_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic osc_clk,
   input  logic lvr_evt,
   input  logic wake_evt,
   input  logic mon_en,
   input  logic fail_scm_sel,
   output logic osc_ok,
   output logic chk_busy,
   output logic scm_on,
   output logic rst_req
);
   logic        osc_rise;
   logic        cm_fail;
   logic        start;
   qchk_state_t st;

   osc_qm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(ref_clk), .rst_n(rst_n), .async_in(osc_clk), .rise(osc_rise));

   osc_qm_miss #(.MISS_CYCLES(MISS_CYCLES)) u_miss (
      .clk(ref_clk), .rst_n(rst_n), .enable(mon_en),
      .osc_rise(osc_rise), .fail(cm_fail));

   assign start = lvr_evt | wake_evt | (cm_fail & fail_scm_sel);

   osc_qm_window #(.WIN_CYCLES(WIN_CYCLES), .OK_EDGES(OK_EDGES)) u_win (
      .clk(ref_clk), .rst_n(rst_n), .start(start),
      .osc_rise(osc_rise), .st(st));

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= cm_fail & ~fail_scm_sel;
   end

   assign osc_ok   = st.ok;
   assign chk_busy = st.busy;
   assign scm_on   = st.scm;

   // R6: reset request is a single-cycle pulse
   p_rst_pulse_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R5: failure with self-clock response restarts the check
   p_fail_scm_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      cm_fail && fail_scm_sel |=> chk_busy && scm_on && !osc_ok);
   // R6: failure with reset response leaves the check state alone
   p_fail_rst_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      cm_fail && !fail_scm_sel && !lvr_evt && !wake_evt && !chk_busy
      |=> $stable(osc_ok) && $stable(scm_on) && !chk_busy);
endmodule

// File: tb/sim_osc_quality_mon.sv
module sim_osc_quality_mon;
   localparam int W = 300;
   localparam int N = 20;
   localparam int T = 20;

   logic clk = 1'b0, rst_n = 1'b0, osc = 1'b0;
   logic lvr = 1'b0, wake = 1'b0, mon_en = 1'b0, sel = 1'b1;
   logic osc_ok, chk_busy, scm_on, rst_req;

   always #10 clk = ~clk;

   osc_quality_mon #(.WIN_CYCLES(W), .OK_EDGES(N), .MISS_CYCLES(T),
                     .SYNC_STAGES(2)) u0 (
      .ref_clk(clk), .rst_n(rst_n), .osc_clk(osc), .lvr_evt(lvr),
      .wake_evt(wake), .mon_en(mon_en), .fail_scm_sel(sel),
      .osc_ok(osc_ok), .chk_busy(chk_busy), .scm_on(scm_on), .rst_req(rst_req));

   int checks = 0, errors = 0, cycles = 0;
   string phase = "R1";

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // oscillator generator: half period in reference cycles, 0 = stopped
   int half = 0, ph = 0;
   always @(negedge clk) begin
      if (half != 0) begin
         ph++;
         if (ph >= half) begin ph = 0; osc = ~osc; end
      end
   end

   // behavioural reference model
   int m_ok = 0, m_busy = 1, m_scm = 1, m_rst = 0;
   int m_win = 0, m_cnt = 0, m_idle = 0;
   bit h0 = 0, h1 = 0, h2 = 0;   // sampled oscillator history, newest first
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_ok = 0; m_busy = 1; m_scm = 1; m_rst = 0;
         m_win = 0; m_cnt = 0; m_idle = 0; h0 = 0; h1 = 0; h2 = 0;
      end else begin
         bit e, f;
         e = h1 && !h2;
         f = 0;
         if (!mon_en || e) m_idle = 0;
         else if (m_idle == T - 1) begin m_idle = 0; f = 1; end
         else m_idle++;
         m_rst = (f && !sel) ? 1 : 0;
         if (lvr || wake || (f && sel)) begin
            m_busy = 1; m_ok = 0; m_scm = 1; m_win = 0; m_cnt = 0;
         end else if (m_busy == 1) begin
            if (e && m_cnt == N - 1) begin
               m_ok = 1; m_busy = 0; m_scm = 0; m_win = 0; m_cnt = 0;
            end else if (m_win == W - 1) begin
               m_win = 0; m_cnt = 0;
            end else begin
               m_win++; m_cnt += int'(e);
            end
         end
         h2 = h1; h1 = h0; h0 = osc;
      end
   end

   // compare on every clock
   always @(negedge clk) begin
      chk(phase, int'(osc_ok), m_ok);
      chk(phase, int'(chk_busy), m_busy);
      chk(phase, int'(scm_on), m_scm);
      chk(phase, int'(rst_req), m_rst);
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_lvr();
      lvr = 1'b1; @(negedge clk); lvr = 1'b0;
   endtask

   int rst_seen;
   task automatic count_rst(int n);
      rst_seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_req) rst_seen++;
      end
   endtask

   initial begin
      step(3);
      chk("R1", int'(chk_busy), 1); chk("R1", int'(scm_on), 1);
      chk("R1", int'(osc_ok), 0);   chk("R1", int'(rst_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(chk_busy), 1); chk("R1", int'(scm_on), 1);

      // R2: fast oscillator passes well inside one window
      phase = "R2"; half = 3; mon_en = 1'b1; sel = 1'b1;
      step(200);
      chk("R2", int'(osc_ok), 1); chk("R2", int'(chk_busy), 0);
      chk("R2", int'(scm_on), 0);

      // R4: low-voltage event restarts from the good state
      phase = "R4"; pulse_lvr();
      chk("R4", int'(chk_busy), 1); chk("R4", int'(osc_ok), 0);
      chk("R4", int'(scm_on), 1);
      step(200);
      chk("R4", int'(osc_ok), 1);
      wake = 1'b1; @(negedge clk); wake = 1'b0;
      chk("R4", int'(chk_busy), 1); chk("R4", int'(osc_ok), 0);

      // R8: fast edges with reset response never fail
      phase = "R8"; sel = 1'b0;
      count_rst(200);
      chk("R8", rst_seen, 0);
      chk("R8", int'(osc_ok), 1);

      // R3: slow oscillator stays just under threshold per window
      phase = "R3"; sel = 1'b1; half = 8; pulse_lvr();
      count_rst(3 * W);
      chk("R3", int'(osc_ok), 0); chk("R3", int'(scm_on), 1);
      chk("R3", int'(chk_busy), 1); chk("R3", rst_seen, 0);

      // R7: stopped oscillator, monitor off
      phase = "R7"; half = 0; mon_en = 1'b0; sel = 1'b0;
      count_rst(5 * T);
      chk("R7", rst_seen, 0);

      // R6: stopped oscillator, reset response
      phase = "R6"; half = 3; sel = 1'b1; mon_en = 1'b1; pulse_lvr();
      step(200);
      chk("R6", int'(osc_ok), 1);
      sel = 1'b0; half = 0;
      count_rst(3 * T + 10);
      chk("R6", rst_seen, 3);
      chk("R6", int'(osc_ok), 1); chk("R6", int'(chk_busy), 0);
      chk("R6", int'(scm_on), 0);

      // R5: stopped oscillator, self-clock response
      phase = "R5"; sel = 1'b1;
      step(T + 5);
      chk("R5", int'(scm_on), 1); chk("R5", int'(osc_ok), 0);
      chk("R5", int'(chk_busy), 1);

      // R9: start trigger in the threshold cycle
      phase = "R9"; half = 3; pulse_lvr();
      for (int i = 0; i < 400; i++) begin
         if (m_cnt == N - 1 && h1 && !h2) break;
         @(negedge clk);
      end
      chk("R9", m_cnt, N - 1);
      pulse_lvr();
      chk("R9", int'(osc_ok), 0); chk("R9", int'(chk_busy), 1);
      step(200);
      chk("R9", int'(osc_ok), 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule